// File: doc/BRIEF.md
# Indexed Configuration Register Space

This block is a byte-wide configuration space that a host reaches through two adjacent I/O addresses. A write to the lower address (the index port) stores a register number. A read or write at the next address (the data port) then reaches the register that this number names. A few registers are global: the chip identity, a chip configuration byte whose bit 0 enables the chip, and a selector that picks one logical unit. Registers from 0x30 upward are banked, so each logical unit has its own copy of the activate byte and of a 16-bit runtime base address.

The GPIO unit adds a second level of indirection. A pin selector picks one of the pins, and two further indices then reach that pin's own configuration byte and event byte. The block drives the GPIO unit's base address and a combined enable straight out to the runtime GPIO logic. Data-port reads return the addressed byte in the same cycle as the read strobe, and writes take effect at the next clock edge.

Top module: `cfg_index_space`

## Requirements
- R1: The index port is at address PORT_BASE and the data port at PORT_BASE+1. A write to the index port stores the index, and a read of the index port returns it. Reads of any other address return 0x00, and writes to any other address change nothing.
- R2: Index 0x20 reads as 0xE5 when ID_VARIANT is 0 and as 0xE9 when it is 1. Writes to index 0x20 are ignored.
- R3: Index 0x21 is an 8-bit read/write chip configuration byte, and bit 0 of it is the chip enable.
- R4: Index 0x07 is an 8-bit read/write logical-unit selector. Only a data write at index 0x07 changes it.
- R5: Index 0x30 is a read/write activate byte. Each unit 0..NUM_UNITS-1 has its own copy of it. When the selector holds NUM_UNITS or more, the banked indices read 0x00 and writes to them are ignored.
- R6: Indices 0x60 and 0x61 are the high and low bytes of the selected unit's 16-bit base address. Each unit has its own copy.
- R7: gpio_base always equals the base address of unit GPIO_UNIT. gpio_en is 1 when bit 0 of the chip configuration byte is 1 and the GPIO unit's activate byte is nonzero. Both outputs change at the clock edge that takes the write.
- R8: With GPIO_UNIT selected, index 0xF0 is the pin selector. Bits 5:4 hold the port number and bits 2:0 the bit within the port, which selects pin port*8+bit. Bits 7:6 and bit 3 read back as 0.
- R9: With GPIO_UNIT selected, indices 0xF1 and 0xF2 read and write the configuration byte and the event byte of the selected pin. Each of the NUM_PINS pins has its own two bytes.
- R10: While a unit other than GPIO_UNIT is selected, indices 0xF0 to 0xF2 read 0x00 and writes to them leave the pin selector and the pin bytes unchanged.
- R11: Indices that are not implemented (for example 0x22 and 0x31) read 0x00, and writes to them are ignored.
- R12: After reset the index, the selector, the chip configuration byte, every activate byte and base address, the pin selector and every pin byte are 0x00. gpio_en and gpio_base are 0.
- R13: io_rdata is 0x00 while io_rd is low. A data-port read shows the addressed byte combinationally in the cycle that io_rd is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_addr | input | ADDR_W | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| gpio_base | output | 16 | Runtime base address of the GPIO unit |
| gpio_en | output | 1 | Chip enabled and GPIO unit active |

## Verification
The bench builds two instances that share one bus. One uses base 0x4E and the second identity code, and the other uses the defaults of base 0x2E and 0xE5. This lets the bench check that each instance decodes only its own port pair, and it covers both identity values. Both instances keep sixteen units and thirty-two pins. With that setting, a selector value of 0x20 reaches the out-of-range bank case, and pin selectors of 0x25, 0x13 and 0xFF reach distinct pins and the read-back masking of the unused selector bits.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

  typedef logic [7:0] byte_t;

  // Register indices; placement is fixed by the host software contract
  localparam byte_t IX_UNIT_SEL = 8'h07;
  localparam byte_t IX_CHIP_ID  = 8'h20;
  localparam byte_t IX_CHIP_CFG = 8'h21;
  localparam byte_t IX_ACTIVATE = 8'h30;
  localparam byte_t IX_BASE_HI  = 8'h60;
  localparam byte_t IX_BASE_LO  = 8'h61;
  localparam byte_t IX_PIN_SEL  = 8'hF0;
  localparam byte_t IX_PIN_CFG  = 8'hF1;
  localparam byte_t IX_PIN_EVT  = 8'hF2;

  // One bus cycle after port decode
  typedef struct packed {
    logic  idx_wr;
    logic  idx_rd;
    logic  dat_wr;
    logic  dat_rd;
    byte_t idx;
    byte_t wdata;
  } cfg_acc_t;

  function automatic byte_t chip_id_value(input int unsigned variant);
    return (variant == 0) ? 8'hE5 : 8'hE9;
  endfunction

endpackage

// File: rtl/cfgsp_port_decode.sv
module cfgsp_port_decode
  import cfgsp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PORT_BASE = 32'h2E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  byte_t             io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output cfg_acc_t          acc
);

  localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(PORT_BASE);
  localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(PORT_BASE + 1);

  logic  hit_idx, hit_dat;
  byte_t idx_q, idx_d;
  logic  idx_en;

  assign hit_idx = (io_addr == IDX_ADDR);
  assign hit_dat = (io_addr == DAT_ADDR);

  // next state of the index latch
  always_comb begin
    idx_en = io_wr && hit_idx;
    idx_d  = idx_q;
    if (idx_en) idx_d = io_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  always_comb begin
    acc.idx_wr = io_wr && hit_idx;
    acc.idx_rd = io_rd && hit_idx;
    acc.dat_wr = io_wr && hit_dat;
    acc.dat_rd = io_rd && hit_dat;
    acc.idx    = idx_q;
    acc.wdata  = io_wdata;
  end

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == IDX_ADDR) |=> (acc.idx == $past(io_wdata)));

  // R1
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && io_addr == IDX_ADDR) |=> $stable(acc.idx));

endmodule

// File: rtl/cfgsp_global_regs.sv
module cfgsp_global_regs
  import cfgsp_pkg::*;
#(
  parameter int unsigned ID_VARIANT = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cfg_acc_t acc,
  output byte_t    chip_cfg,
  output byte_t    unit_sel,
  output byte_t    rdata
);

  localparam byte_t ID_BYTE = chip_id_value(ID_VARIANT);

  byte_t cfg_q, cfg_d, sel_q, sel_d;
  logic  cfg_en, sel_en;

  always_comb begin
    cfg_en = acc.dat_wr && (acc.idx == IX_CHIP_CFG);
    sel_en = acc.dat_wr && (acc.idx == IX_UNIT_SEL);
    cfg_d  = cfg_en ? acc.wdata : cfg_q;
    sel_d  = sel_en ? acc.wdata : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sel_q <= '0;
    end else begin
      if (cfg_en) cfg_q <= cfg_d;
      if (sel_en) sel_q <= sel_d;
    end
  end

  always_comb begin
    unique case (acc.idx)
      IX_CHIP_ID:  rdata = ID_BYTE;
      IX_CHIP_CFG: rdata = cfg_q;
      IX_UNIT_SEL: rdata = sel_q;
      default:     rdata = '0;
    endcase
  end

  assign chip_cfg = cfg_q;
  assign unit_sel = sel_q;

  // R4
  sel_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc.dat_wr && acc.idx == IX_UNIT_SEL) |=> $stable(unit_sel));

  // R3
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.dat_wr && acc.idx == IX_CHIP_CFG) |=> (chip_cfg == $past(acc.wdata)));

endmodule

// File: rtl/cfgsp_unit_bank.sv
module cfgsp_unit_bank
  import cfgsp_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 16,
  parameter int unsigned GPIO_UNIT = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  cfg_acc_t    acc,
  input  byte_t       unit_sel,
  output byte_t       rdata,
  output logic [15:0] gpio_base,
  output byte_t       gpio_act
);

  localparam byte_t GPIO_SEL = byte_t'(GPIO_UNIT);

  byte_t act_q [NUM_UNITS];
  byte_t bhi_q [NUM_UNITS];
  byte_t blo_q [NUM_UNITS];

  logic unit_ok;
  logic wr_act, wr_bhi, wr_blo;

  assign unit_ok = (unit_sel < byte_t'(NUM_UNITS));

  always_comb begin
    wr_act = acc.dat_wr && unit_ok && (acc.idx == IX_ACTIVATE);
    wr_bhi = acc.dat_wr && unit_ok && (acc.idx == IX_BASE_HI);
    wr_blo = acc.dat_wr && unit_ok && (acc.idx == IX_BASE_LO);
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic  hit;
    logic  en_act, en_bhi, en_blo;
    byte_t act_d, bhi_d, blo_d;

    assign hit = (unit_sel == byte_t'(u));

    always_comb begin
      en_act = wr_act && hit;
      en_bhi = wr_bhi && hit;
      en_blo = wr_blo && hit;
      act_d  = en_act ? acc.wdata : act_q[u];
      bhi_d  = en_bhi ? acc.wdata : bhi_q[u];
      blo_d  = en_blo ? acc.wdata : blo_q[u];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q[u] <= '0;
        bhi_q[u] <= '0;
        blo_q[u] <= '0;
      end else begin
        if (en_act) act_q[u] <= act_d;
        if (en_bhi) bhi_q[u] <= bhi_d;
        if (en_blo) blo_q[u] <= blo_d;
      end
    end
  end

  // read mux over the selected bank
  always_comb begin
    byte_t act_s, bhi_s, blo_s;
    act_s = '0;
    bhi_s = '0;
    blo_s = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (unit_sel == byte_t'(u)) begin
        act_s = act_q[u];
        bhi_s = bhi_q[u];
        blo_s = blo_q[u];
      end
    end
    unique case (acc.idx)
      IX_ACTIVATE: rdata = act_s;
      IX_BASE_HI:  rdata = bhi_s;
      IX_BASE_LO:  rdata = blo_s;
      default:     rdata = '0;
    endcase
  end

  assign gpio_base = {bhi_q[GPIO_UNIT], blo_q[GPIO_UNIT]};
  assign gpio_act  = act_q[GPIO_UNIT];

  // R6
  gpio_base_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.dat_wr && acc.idx == IX_BASE_HI && unit_sel == GPIO_SEL)
      |=> (gpio_base[15:8] == $past(acc.wdata)));

  // R5
  other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.dat_wr && unit_sel != GPIO_SEL) |=> ($stable(gpio_base) && $stable(gpio_act)));

endmodule

// File: rtl/cfgsp_pin_store.sv
module cfgsp_pin_store
  import cfgsp_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned GPIO_UNIT = 7
) (
  input  logic     clk,
  input  logic     rst_n,
  input  cfg_acc_t acc,
  input  byte_t    unit_sel,
  output byte_t    rdata
);

  localparam int unsigned NUM_PORTS = NUM_PINS / 8;
  localparam int unsigned PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int unsigned PIN_W     = PORT_W + 3;
  localparam byte_t       GPIO_SEL  = byte_t'(GPIO_UNIT);

  logic [PORT_W-1:0] port_q, port_d;
  logic [2:0]        bit_q, bit_d;
  logic              sel_en;
  logic              gpio_on;
  logic [PIN_W-1:0]  pin_idx;
  byte_t             sel_byte;

  byte_t cfg_q [NUM_PINS];
  byte_t evt_q [NUM_PINS];
  byte_t cfg_cur, evt_cur;

  assign gpio_on = (unit_sel == GPIO_SEL);
  assign pin_idx = {port_q, bit_q};

  always_comb begin
    sel_en = acc.dat_wr && gpio_on && (acc.idx == IX_PIN_SEL);
    port_d = sel_en ? acc.wdata[4 +: PORT_W] : port_q;
    bit_d  = sel_en ? acc.wdata[2:0] : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      bit_q  <= '0;
    end else if (sel_en) begin
      port_q <= port_d;
      bit_q  <= bit_d;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic  here;
    logic  en_cfg, en_evt;
    byte_t cfg_d, evt_d;

    assign here = (pin_idx == PIN_W'(p));

    always_comb begin
      en_cfg = acc.dat_wr && gpio_on && here && (acc.idx == IX_PIN_CFG);
      en_evt = acc.dat_wr && gpio_on && here && (acc.idx == IX_PIN_EVT);
      cfg_d  = en_cfg ? acc.wdata : cfg_q[p];
      evt_d  = en_evt ? acc.wdata : evt_q[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[p] <= '0;
        evt_q[p] <= '0;
      end else begin
        if (en_cfg) cfg_q[p] <= cfg_d;
        if (en_evt) evt_q[p] <= evt_d;
      end
    end
  end

  always_comb begin
    sel_byte = '0;
    sel_byte[4 +: PORT_W] = port_q;
    sel_byte[2:0]         = bit_q;
  end

  assign cfg_cur = cfg_q[pin_idx];
  assign evt_cur = evt_q[pin_idx];

  always_comb begin
    rdata = '0;
    if (gpio_on) begin
      unique case (acc.idx)
        IX_PIN_SEL: rdata = sel_byte;
        IX_PIN_CFG: rdata = cfg_cur;
        IX_PIN_EVT: rdata = evt_cur;
        default:    rdata = '0;
      endcase
    end
  end

  // R9
  pin_cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.dat_wr && gpio_on && acc.idx == IX_PIN_CFG) |=> (cfg_cur == $past(acc.wdata)));

  // R10
  pin_sel_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.dat_wr && !gpio_on) |=> $stable(pin_idx));

endmodule

// File: rtl/cfg_index_space.sv
module cfg_index_space
  import cfgsp_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PORT_BASE  = 32'h2E,
  parameter int unsigned ID_VARIANT = 0,
  parameter int unsigned NUM_UNITS  = 16,
  parameter int unsigned GPIO_UNIT  = 7,
  parameter int unsigned NUM_PINS   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic [15:0]       gpio_base,
  output logic              gpio_en
);

  localparam byte_t ID_BYTE = chip_id_value(ID_VARIANT);

  logic     rst_meta_q, rst_sync_q;
  cfg_acc_t acc;
  byte_t    chip_cfg, unit_sel, gpio_act;
  byte_t    rd_glob, rd_bank, rd_pin;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  cfgsp_port_decode #(
    .ADDR_W    (ADDR_W),
    .PORT_BASE (PORT_BASE)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .acc      (acc)
  );

  cfgsp_global_regs #(
    .ID_VARIANT (ID_VARIANT)
  ) u_global (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .acc      (acc),
    .chip_cfg (chip_cfg),
    .unit_sel (unit_sel),
    .rdata    (rd_glob)
  );

  cfgsp_unit_bank #(
    .NUM_UNITS (NUM_UNITS),
    .GPIO_UNIT (GPIO_UNIT)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .acc       (acc),
    .unit_sel  (unit_sel),
    .rdata     (rd_bank),
    .gpio_base (gpio_base),
    .gpio_act  (gpio_act)
  );

  cfgsp_pin_store #(
    .NUM_PINS  (NUM_PINS),
    .GPIO_UNIT (GPIO_UNIT)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .acc      (acc),
    .unit_sel (unit_sel),
    .rdata    (rd_pin)
  );

  // each source returns zero outside its own indices
  always_comb begin
    io_rdata = '0;
    if (acc.idx_rd)      io_rdata = acc.idx;
    else if (acc.dat_rd) io_rdata = rd_glob | rd_bank | rd_pin;
  end

  assign gpio_en = chip_cfg[0] && (gpio_act != '0);

  // R13
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !io_rd |-> (io_rdata == '0));

  // R2
  chip_id_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (acc.dat_rd && acc.idx == IX_CHIP_ID) |-> (io_rdata == ID_BYTE));

  // R7
  gpio_en_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(gpio_en) |-> $past(acc.dat_wr));

endmodule

// File: tb/sim_cfg_index_space.sv
`timescale 1ns/1ps
module sim_cfg_index_space;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  rdata0, rdata1;
  logic [15:0] base0, base1;
  logic        en0, en1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_index_space #(
    .ADDR_W(16), .PORT_BASE(32'h4E), .ID_VARIANT(1),
    .NUM_UNITS(16), .GPIO_UNIT(7), .NUM_PINS(32)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(rdata0),
    .gpio_base(base0), .gpio_en(en0)
  );

  cfg_index_space u1 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(rdata1),
    .gpio_base(base1), .gpio_en(en1)
  );

  // {is_read, index, value}: value is written data or expected read data
  localparam int NV = 48;
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'h20, 8'hE9}, {1'b0, 8'h20, 8'h00}, {1'b1, 8'h20, 8'hE9},
    {1'b0, 8'h21, 8'h01}, {1'b1, 8'h21, 8'h01},
    {1'b0, 8'h07, 8'h07}, {1'b1, 8'h07, 8'h07},
    {1'b0, 8'h60, 8'h12}, {1'b0, 8'h61, 8'h34}, {1'b1, 8'h60, 8'h12}, {1'b1, 8'h61, 8'h34},
    {1'b0, 8'h30, 8'h01}, {1'b1, 8'h30, 8'h01},
    {1'b0, 8'hF0, 8'h2D}, {1'b1, 8'hF0, 8'h25},
    {1'b0, 8'hF1, 8'hA5}, {1'b0, 8'hF2, 8'h3C},
    {1'b0, 8'hF0, 8'h13}, {1'b0, 8'hF1, 8'h5A}, {1'b1, 8'hF1, 8'h5A}, {1'b1, 8'hF2, 8'h00},
    {1'b0, 8'hF0, 8'h25}, {1'b1, 8'hF1, 8'hA5}, {1'b1, 8'hF2, 8'h3C},
    {1'b0, 8'hF0, 8'hFF}, {1'b1, 8'hF0, 8'h37},
    {1'b0, 8'h07, 8'h03}, {1'b1, 8'h30, 8'h00}, {1'b1, 8'h60, 8'h00},
    {1'b0, 8'h60, 8'h99}, {1'b1, 8'h60, 8'h99}, {1'b1, 8'hF1, 8'h00},
    {1'b0, 8'hF0, 8'h25}, {1'b0, 8'hF1, 8'h77},
    {1'b0, 8'h07, 8'h07}, {1'b1, 8'h60, 8'h12}, {1'b1, 8'hF0, 8'h37},
    {1'b0, 8'hF0, 8'h25}, {1'b1, 8'hF1, 8'hA5},
    {1'b0, 8'h22, 8'h55}, {1'b1, 8'h22, 8'h00}, {1'b1, 8'h31, 8'h00},
    {1'b0, 8'h07, 8'h20}, {1'b1, 8'h30, 8'h00}, {1'b0, 8'h30, 8'hFF}, {1'b1, 8'h30, 8'h00},
    {1'b0, 8'h07, 8'h07}, {1'b1, 8'h30, 8'h01}
  };

  function automatic string req_of(input int i);
    if (i < 3)       return "R2";
    else if (i < 5)  return "R3";
    else if (i < 7)  return "R4";
    else if (i < 11) return "R6";
    else if (i < 13) return "R5";
    else if (i < 15) return "R8";
    else if (i < 24) return "R9";
    else if (i < 26) return "R8";
    else if (i < 31) return "R5";
    else if (i < 39) return "R10";
    else if (i < 42) return "R11";
    else             return "R5";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_rd = 1'b0; io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [7:0] d0, output logic [7:0] d1);
    @(negedge clk);
    io_wr = 1'b0; io_addr = a; io_rd = 1'b1;
    #1;
    d0 = rdata0;
    d1 = rdata1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  initial begin
    logic [7:0] r0, r1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12", base0, 16'h0000);
    check("R12", en0, 0);
    bus_rd(16'h004E, r0, r1);
    check("R12", r0, 8'h00);
    bus_wr(16'h004E, 8'h07); bus_rd(16'h004F, r0, r1); check("R12", r0, 8'h00);
    bus_wr(16'h004E, 8'h21); bus_rd(16'h004F, r0, r1); check("R12", r0, 8'h00);
    bus_wr(16'h004E, 8'h30); bus_rd(16'h004F, r0, r1); check("R12", r0, 8'h00);
    bus_wr(16'h004E, 8'h60); bus_rd(16'h004F, r0, r1); check("R12", r0, 8'h00);

    // R13: strobe low gives zero even with data port addressed
    @(negedge clk);
    io_addr = 16'h004F; io_rd = 1'b0;
    #1;
    check("R13", rdata0, 8'h00);

    for (int i = 0; i < NV; i++) begin
      bus_wr(16'h004E, VEC[i][15:8]);
      if (VEC[i][16]) begin
        bus_rd(16'h004F, r0, r1);
        check(req_of(i), r0, VEC[i][7:0]);
      end else begin
        bus_wr(16'h004F, VEC[i][7:0]);
      end
    end

    // R7: outputs track GPIO unit base and enables
    check("R7", base0, 16'h1234);
    check("R7", en0, 1);
    bus_wr(16'h004E, 8'h21); bus_wr(16'h004F, 8'h00);
    check("R7", en0, 0);
    bus_wr(16'h004F, 8'h01);
    check("R7", en0, 1);
    bus_wr(16'h004E, 8'h30); bus_wr(16'h004F, 8'h00);
    check("R7", en0, 0);
    check("R7", base0, 16'h1234);

    // R1: index read-back, decode isolation between port pairs
    bus_wr(16'h004E, 8'h61);
    bus_rd(16'h004E, r0, r1);
    check("R1", r0, 8'h61);
    bus_wr(16'h002E, 8'h20);
    bus_rd(16'h004E, r0, r1);
    check("R1", r0, 8'h61);
    bus_rd(16'h002F, r0, r1);
    check("R2", r1, 8'hE5);
    check("R1", r0, 8'h00);
    bus_rd(16'h0050, r0, r1);
    check("R1", r0, 8'h00);
    bus_wr(16'h002E, 8'h60); bus_wr(16'h002F, 8'hAB);
    check("R1", base0, 16'h1234);
    check("R12", base1, 16'h0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule